// File: doc/BRIEF.md
# Start-of-Frame Byte Tracker

This block sits in a base device on the byte path between a UART receiver and a daisy-chain serializer. For every byte that crosses it, it decides whether that byte opens a new command frame, and it raises a start-of-frame flag beside the byte. The serializer copies that flag into the frame-start bit of the outgoing daisy-chain byte.

The first byte of a frame is the initialization byte. Its low bits give the payload length, encoded as the number of payload bytes minus one. The frame also carries a fixed number of further bytes, set by a parameter, for the header fields and the CRC. The tracker loads a down-counter from the initialization byte and decrements it once for each accepted byte. The byte that follows the last counted byte is flagged as the next frame start.

A communication-clear pulse restarts the tracking at any point, so the next accepted byte is always flagged. Data and the valid/ready handshake pass straight through with no added latency.

Top module: `sof_frame_tracker`

## Requirements
- R1: After reset, the first byte accepted (in_valid and out_ready both high on a clock edge) is presented with out_sof = 1.
- R2: out_data always equals in_data, and out_valid always equals in_valid, in the same cycle.
- R3: in_ready always equals out_ready, in the same cycle.
- R4: When a flagged byte is accepted, its bits [SIZE_BITS-1:0] (default 3 bits) hold N. Exactly N + 1 + EXTRA_BYTES further accepted bytes follow with out_sof = 0, and the byte after them has out_sof = 1.
- R5: Every byte inside a frame, after the initialization byte and up to the last counted byte, is presented with out_sof = 0.
- R6: A cycle in which no byte is accepted does not advance the count. While in_valid is high and out_ready is low, out_sof stays unchanged.
- R7: A comm_clear pulse on a clock edge with no accepted byte causes the next accepted byte to carry out_sof = 1, whatever the remaining count.
- R8: If comm_clear is high on the same edge as an accepted byte, that byte is flagged according to the tracking state before the clear, and the next accepted byte carries out_sof = 1.
- R9: Bits [7:SIZE_BITS] of the initialization byte have no effect on the frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| comm_clear | input | 1 | One-cycle request to restart frame tracking |
| in_valid | input | 1 | Upstream byte valid |
| in_data | input | 8 | Upstream byte |
| in_ready | output | 1 | Upstream ready (equals out_ready) |
| out_valid | output | 1 | Downstream byte valid (equals in_valid) |
| out_data | output | 8 | Downstream byte (equals in_data) |
| out_sof | output | 1 | Start-of-frame flag for the presented byte |
| out_ready | input | 1 | Downstream ready |

## Verification
The bench sweeps every length code, with varied upper bits in the initialization byte. A design that decodes the wrong field, or that miscounts by one, misplaces the next flagged byte. Stalls are inserted inside frames, so a counter that decrements on valid alone ends the frame early. Clear pulses are sent mid-frame, during the wait for an initialization byte, and on the same edge as an accepted byte. A design that lets the count override the clear, or that flags the coincident byte itself, shows the wrong flag on the byte presented next.

// File: rtl/sof_trk_pkg.sv
// Package: shared types for the start-of-frame tracker.
// Assumes nothing beyond a two-state tracking machine.
package sof_trk_pkg;
    typedef enum logic [0:0] {
        TRK_AWAIT_INIT = 1'b0,
        TRK_IN_FRAME   = 1'b1
    } trk_state_e;
endpackage

// File: rtl/sof_len_decode.sv
// Module: turns an initialization byte into the number of bytes that
// follow it in the frame, minus one (the counter's load value).
// Assumes the length code is in the low SIZE_BITS bits and means
// payload bytes minus one; upper bits are ignored.
module sof_len_decode #(
    parameter int SIZE_BITS   = 3,
    parameter int EXTRA_BYTES = 3,
    parameter int CNT_W       = 4
) (
    input  logic [7:0]       init_byte,
    output logic [CNT_W-1:0] load_val
);
    logic [SIZE_BITS-1:0] len_code;

    // Extract the length code from the low bits only.
    always_comb begin
        len_code = init_byte[SIZE_BITS-1:0];
    end

    // Remaining bytes = code + 1 + EXTRA; the counter ends at zero, so load remaining - 1.
    always_comb begin
        load_val = CNT_W'(len_code) + CNT_W'(EXTRA_BYTES);
    end
endmodule

// File: rtl/sof_frame_counter.sv
// Module: down-counter of bytes left in the current frame.
// Assumes load and dec never both high; load wins if they are.
module sof_frame_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             at_zero
);
    logic [CNT_W-1:0] remaining;

    // Hold, load or decrement the remaining-byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec && remaining != '0) begin
            remaining <= remaining - 1'b1;
        end
    end

    // Flag the last counted byte of the frame.
    always_comb begin
        at_zero = (remaining == '0);
    end
endmodule

// File: rtl/sof_frame_fsm.sv
// Module: tracking state machine; waits for an initialization byte,
// then counts body bytes until the counter reaches zero.
// Assumes accept is the completed handshake; clear outranks counting.
module sof_frame_fsm
    import sof_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic clear,
    input  logic cnt_zero,
    output logic cnt_load,
    output logic cnt_dec,
    output logic flag_sof
);
    trk_state_e state_q, state_d;

    // Next-state and counter controls.
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            TRK_AWAIT_INIT: begin
                if (accept) begin
                    cnt_load = 1'b1;
                    state_d  = TRK_IN_FRAME;
                end
            end
            TRK_IN_FRAME: begin
                if (accept) begin
                    if (cnt_zero) state_d = TRK_AWAIT_INIT;
                    else          cnt_dec = 1'b1;
                end
            end
            default: state_d = TRK_AWAIT_INIT;
        endcase
        if (clear) state_d = TRK_AWAIT_INIT;
    end

    // State register; reset lands in the wait-for-init state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_AWAIT_INIT;
        else        state_q <= state_d;
    end

    // The presented byte is a frame start while waiting for an init byte.
    always_comb begin
        flag_sof = (state_q == TRK_AWAIT_INIT);
    end
endmodule

// File: rtl/sof_frame_tracker.sv
// Module (top): flags each byte on the UART-to-daisy-chain path with a
// start-of-frame bit derived from the init byte's length code.
// Assumes comm_clear is synchronous to clk; the handshake passes through.
module sof_frame_tracker #(
    parameter int SIZE_BITS   = 3,
    parameter int EXTRA_BYTES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       comm_clear,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_sof,
    input  logic       out_ready
);
    localparam int MAX_REM = (1 << SIZE_BITS) + EXTRA_BYTES;
    localparam int CNT_W   = $clog2(MAX_REM + 1);

    logic             accept;
    logic             cnt_load;
    logic             cnt_dec;
    logic             cnt_zero;
    logic [CNT_W-1:0] load_val;

    // Straight-through data and handshake.
    always_comb begin
        in_ready  = out_ready;
        out_valid = in_valid;
        out_data  = in_data;
        accept    = in_valid && out_ready;
    end

    sof_len_decode #(
        .SIZE_BITS  (SIZE_BITS),
        .EXTRA_BYTES(EXTRA_BYTES),
        .CNT_W      (CNT_W)
    ) u_dec (
        .init_byte(in_data),
        .load_val (load_val)
    );

    sof_frame_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(load_val),
        .dec     (cnt_dec),
        .at_zero (cnt_zero)
    );

    sof_frame_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .clear   (comm_clear),
        .cnt_zero(cnt_zero),
        .cnt_load(cnt_load),
        .cnt_dec (cnt_dec),
        .flag_sof(out_sof)
    );
endmodule

// File: rtl/sof_frame_tracker_chk.sv
// Checker: port-level properties of the tracker, bound to the top.
module sof_frame_tracker_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       comm_clear,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_ready,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_sof,
    input logic       out_ready
);
    a_r1_reset_sof: assert property (@(posedge clk)
        $rose(rst_n) |-> out_sof);
    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid == in_valid) && (out_data == in_data));
    a_r3_ready: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == out_ready);
    a_r5_body_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_ready && out_sof && !comm_clear) |=> !out_sof);
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(in_valid && out_ready) && !comm_clear) |=> $stable(out_sof));
    a_r7_clear_forces: assert property (@(posedge clk) disable iff (!rst_n)
        comm_clear |=> out_sof);
endmodule

bind sof_frame_tracker sof_frame_tracker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .comm_clear(comm_clear),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_ready (out_ready)
);

// File: tb/sim_sof_frame_tracker.sv
module sim_sof_frame_tracker;
    localparam int SB = 3;
    localparam int EX = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       comm_clear = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       out_ready = 1'b0;
    logic       in_ready, out_valid, out_sof;
    logic [7:0] out_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit exp_sof = 1'b1;
    int rem = 0;

    always #10 clk = ~clk;

    sof_frame_tracker #(.SIZE_BITS(SB), .EXTRA_BYTES(EX)) u0 (
        .clk(clk), .rst_n(rst_n), .comm_clear(comm_clear),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_ready(out_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Update the bench model for one accepted byte.
    function automatic void model_accept(input logic [7:0] b);
        if (exp_sof) begin
            rem = int'(b[SB-1:0]) + 1 + EX;
            exp_sof = 1'b0;
        end else begin
            rem--;
            if (rem == 0) exp_sof = 1'b1;
        end
    endfunction

    // Present one byte with optional stall cycles and optional coincident clear.
    task automatic send(input logic [7:0] b, input int stall, input bit clr);
        @(negedge clk);
        in_valid = 1'b1; in_data = b; out_ready = 1'b0; comm_clear = 1'b0;
        for (int s = 0; s < stall; s++) begin
            #1;
            chk(in_ready == 1'b0, "R3 ready low", in_ready, 0);
            chk(out_sof == exp_sof, "R6 stall sof", out_sof, exp_sof);
            @(negedge clk);
        end
        out_ready = 1'b1; comm_clear = clr;
        #1;
        chk(out_sof == exp_sof, exp_sof ? "R4 frame start" : "R5 body byte", out_sof, exp_sof);
        chk(out_data == b && out_valid && in_ready, "R2 passthru", out_data, b);
        @(posedge clk);
        model_accept(b);
        if (clr) exp_sof = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; out_ready = 1'b0; comm_clear = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        in_valid = 1'b0; comm_clear = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        exp_sof = 1'b1;
        @(negedge clk);
        comm_clear = 1'b0; out_ready = 1'b0;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_sof == 1'b1, "R1 reset sof", out_sof, 1);
        // R4 R5 R9: every length code, varied upper bits, with stalls (R6).
        for (int sz = 0; sz < 8; sz++) begin
            for (int up = 0; up < 3; up++) begin
                logic [7:0] ib;
                ib = 8'((up * 83 + sz * 29) << SB) | 8'(sz);
                send(ib, up, 1'b0);
                for (int k = 0; k < sz + 1 + EX; k++)
                    send(8'((k * 53 + sz + 7) & 8'hFF), (k % 3 == 1) ? 2 : 0, 1'b0);
                chk(exp_sof == 1'b1, "R4 model wrap", exp_sof, 1);
            end
        end
        // R7: clear mid-frame.
        send(8'hF7, 0, 1'b0);
        send(8'h01, 0, 1'b0);
        send(8'h02, 1, 1'b0);
        pulse_clear();
        #1 chk(out_sof == 1'b1, "R7 clear mid-frame", out_sof, 1);
        send(8'h00, 0, 1'b0);
        for (int k = 0; k < 1 + EX; k++) send(8'h07, 0, 1'b0);
        // R7: clear while waiting for init byte.
        pulse_clear();
        send(8'h02, 0, 1'b0);
        // R8: clear coincident with an accepted body byte.
        send(8'h11, 0, 1'b1);
        #1 chk(out_sof == 1'b1, "R8 coincident clear", out_sof, 1);
        // R8: clear coincident with an accepted init byte.
        send(8'h05, 0, 1'b1);
        send(8'hFF, 0, 1'b0);
        for (int k = 0; k < 8 + EX; k++) send(8'hA5, k % 2, 1'b0);
        chk(exp_sof == 1'b1, "R4 max length", exp_sof, 1);
        send(8'h03, 0, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule